// File: doc/BRIEF.md
# Configurable Logic Macrocell with Routed Inputs and Output Polarity

This block is one logic cell of a programmable logic fabric. A small set of local inputs is taken from a shared interconnect bus. Each local input has its own selector, and each selector can reach only a fixed group of bus lines. A programmable product-term plane forms AND terms from those inputs in true or complemented form. An OR over the enabled terms gives a sum-of-products value.

That value goes through an XOR that can invert it. The output is then either taken directly or taken from a flip-flop that captures the inverted-or-not value on the rising clock edge. The chosen output is also driven back as a feedback line, so the surrounding fabric can route it onto the bus for this cell or for another.

All configuration is presented as static input bits, held by whatever loads the fabric. With the defaults there are 16 bus lines, 4 local inputs and 4 product terms.

Top module: `mcell_top`

## Requirements
- R1: Local input k (k = 0..3) equals bus line k + 4*s, where s is the 2-bit field sel_i[2k+1:2k]. Bus lines outside the group {k, k+4, k+8, k+12} have no effect on local input k.
- R2: Product term p (p = 0..3) is the AND of its literals. Bit p*4+i of pt_true_i adds local input i as a literal, and bit p*4+i of pt_comp_i adds its complement. A term with no literals evaluates to 1.
- R3: A term that has both the true and the complemented literal of the same input evaluates to 0 for every input value.
- R4: The sum-of-products value is the OR of the terms p whose bit pt_or_i[p] is 1. When no term is enabled, the value is 0.
- R5: When pol_inv_i is 1, the sum-of-products value is complemented before the output stage and before the register.
- R6: When reg_sel_i is 0, mc_o follows the polarity-adjusted value in the same cycle, with no clock edge involved.
- R7: When reg_sel_i is 1, mc_o shows the polarity-adjusted value captured at the most recent rising edge of clk.
- R8: When rst is 1 at a rising edge, the register is cleared to 0. In registered mode mc_o is then 0. In combinational mode mc_o is not affected by rst.
- R9: fb_o always equals mc_o. When fb_o is routed back onto the bus in registered mode, the cell can feed its own input; a term formed from the complement of that input makes mc_o toggle on every edge.
- R10: The register captures on every edge whatever the mode. After a switch from combinational to registered mode, mc_o at once shows the value captured at the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register captures on the rising edge |
| rst | input | 1 | Synchronous active-high clear of the register |
| bus_i | input | 16 | Global interconnect lines |
| sel_i | input | 8 | Per-input group selects, 2 bits per local input |
| pt_true_i | input | 16 | True-literal enables, 4 bits per term |
| pt_comp_i | input | 16 | Complement-literal enables, 4 bits per term |
| pt_or_i | input | 4 | Per-term enable into the OR |
| pol_inv_i | input | 1 | 1 inverts the sum-of-products value |
| reg_sel_i | input | 1 | 1 selects the registered output, 0 the combinational one |
| mc_o | output | 1 | Macrocell output |
| fb_o | output | 1 | Feedback copy of the output for the interconnect |

## Verification
Each selector is swept through all four of its codes with a single line high, and then with every other line high. A selector decoded with the wrong stride or offset would pick up a line outside its group and give the wrong output.

Several cases exercise the product-term plane. A term with contradicting literals must give 0, so a plane that lets one literal win would give 1. An empty term must give 1, and with no term enabled the result must be 0. Polarity is checked in both modes, so a design that applied it after the register would be off by one cycle in registered mode.

Reset is applied in both modes, and a design that also gated the combinational path with reset would fail. A self-feedback toggle loop and random switching between the two modes check the ordering of capture and bypass, and a cell that held its register while bypassed would show stale data after the switch.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_mode_e;

  // Bus line reached by selector k when its select code is s.
  function automatic int unsigned route_line(input int unsigned k,
                                             input int unsigned s,
                                             input int unsigned n_in);
    return k + n_in * s;
  endfunction

  // One product term: true literals require 1, complement literals require 0.
  function automatic logic term_value(input logic [31:0] loc,
                                      input logic [31:0] tmask,
                                      input logic [31:0] cmask);
    logic [31:0] miss;
    miss = (tmask & ~loc) | (cmask & loc);
    return ~|miss;
  endfunction

endpackage

// File: rtl/mcell_route.sv
module mcell_route
  import mcell_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int BUS_W = 16,
  localparam int GRP   = BUS_W / N_IN,
  localparam int SEL_W = (GRP > 1) ? $clog2(GRP) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [BUS_W-1:0]        bus_i,
  input  logic [N_IN*SEL_W-1:0]   sel_i,
  output logic [N_IN-1:0]         loc_o
);

  for (genvar k = 0; k < N_IN; k++) begin : g_mux
    logic [GRP-1:0]   grp;
    logic [SEL_W-1:0] sel;

    for (genvar g = 0; g < GRP; g++) begin : g_tap
      assign grp[g] = bus_i[route_line(k, g, N_IN)];
    end

    assign sel      = sel_i[k*SEL_W +: SEL_W];
    assign loc_o[k] = grp[sel];

    AST_ROUTE_GROUP_HIGH: assert property (@(posedge clk) disable iff (rst)
      (&grp) |-> loc_o[k]);   // R1
    AST_ROUTE_GROUP_LOW: assert property (@(posedge clk) disable iff (rst)
      (~|grp) |-> !loc_o[k]); // R1
  end

endmodule

// File: rtl/mcell_pterm.sv
module mcell_pterm
  import mcell_pkg::*;
#(
  parameter int N_IN = 4,
  parameter int N_PT = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_IN-1:0]        loc_i,
  input  logic [N_PT*N_IN-1:0]   pt_true_i,
  input  logic [N_PT*N_IN-1:0]   pt_comp_i,
  input  logic [N_PT-1:0]        pt_or_i,
  output logic                   sop_o
);

  logic [N_PT-1:0] term;

  for (genvar p = 0; p < N_PT; p++) begin : g_term
    logic [N_IN-1:0] tm;
    logic [N_IN-1:0] cm;
    logic [31:0]     loc_x, tm_x, cm_x;

    assign tm    = pt_true_i[p*N_IN +: N_IN];
    assign cm    = pt_comp_i[p*N_IN +: N_IN];
    assign loc_x = 32'(loc_i);
    assign tm_x  = 32'(tm);
    assign cm_x  = 32'(cm);
    assign term[p] = term_value(loc_x, tm_x, cm_x);

    AST_TERM_CONFLICT: assert property (@(posedge clk) disable iff (rst)
      (|(tm & cm)) |-> !term[p]);   // R3
    AST_TERM_EMPTY: assert property (@(posedge clk) disable iff (rst)
      (~|(tm | cm)) |-> term[p]);   // R2
  end

  assign sop_o = |(term & pt_or_i);

  AST_NO_TERM_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (~|pt_or_i) |-> !sop_o);  // R4

endmodule

// File: rtl/mcell_out.sv
module mcell_out
  import mcell_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sop_i,
  input  logic pol_inv_i,
  input  logic reg_sel_i,
  output logic d_pol_o,
  output logic q_o,
  output logic mc_o
);

  out_mode_e mode;

  assign mode    = out_mode_e'(reg_sel_i);
  assign d_pol_o = sop_i ^ pol_inv_i;

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= d_pol_o;
  end

  assign mc_o = (mode == OUT_REG) ? q_o : d_pol_o;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !q_o);  // R8

endmodule

// File: rtl/mcell_top.sv
module mcell_top
  import mcell_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int N_IN  = 4,
  parameter int N_PT  = 4,
  localparam int GRP   = BUS_W / N_IN,
  localparam int SEL_W = (GRP > 1) ? $clog2(GRP) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [BUS_W-1:0]      bus_i,
  input  logic [N_IN*SEL_W-1:0] sel_i,
  input  logic [N_PT*N_IN-1:0]  pt_true_i,
  input  logic [N_PT*N_IN-1:0]  pt_comp_i,
  input  logic [N_PT-1:0]       pt_or_i,
  input  logic                  pol_inv_i,
  input  logic                  reg_sel_i,
  output logic                  mc_o,
  output logic                  fb_o
);

  logic [N_IN-1:0] loc_w;
  logic            sop_w;
  logic            d_pol_w;
  logic            q_w;

  mcell_route #(.N_IN(N_IN), .BUS_W(BUS_W)) u_route (
    .clk   (clk),
    .rst   (rst),
    .bus_i (bus_i),
    .sel_i (sel_i),
    .loc_o (loc_w)
  );

  mcell_pterm #(.N_IN(N_IN), .N_PT(N_PT)) u_pterm (
    .clk       (clk),
    .rst       (rst),
    .loc_i     (loc_w),
    .pt_true_i (pt_true_i),
    .pt_comp_i (pt_comp_i),
    .pt_or_i   (pt_or_i),
    .sop_o     (sop_w)
  );

  mcell_out u_out (
    .clk       (clk),
    .rst       (rst),
    .sop_i     (sop_w),
    .pol_inv_i (pol_inv_i),
    .reg_sel_i (reg_sel_i),
    .d_pol_o   (d_pol_w),
    .q_o       (q_w),
    .mc_o      (mc_o)
  );

  assign fb_o = mc_o;

  AST_COMB_PATH: assert property (@(posedge clk) disable iff (rst)
    !reg_sel_i |-> (mc_o == (sop_w ^ pol_inv_i)));  // R6
  AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (q_w == $past(sop_w ^ pol_inv_i)));    // R7
  AST_REG_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    reg_sel_i |-> (fb_o == q_w));                   // R10

endmodule

// File: tb/mcell_top_tb_top.sv
module mcell_top_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] drv;
  logic        loop_en;
  logic [7:0]  sel;
  logic [15:0] pt_t, pt_c;
  logic [3:0]  pt_or;
  logic        pol, rsel;
  logic        mc, fb;
  logic        mq = 1'b0;
  int          checks = 0;
  int          fails  = 0;
  string       cur_req = "R8";

  always #10 clk = ~clk;

  wire [15:0] bus = loop_en ? {fb, drv[14:0]} : drv;

  mcell_top dut_i (
    .clk(clk), .rst(rst), .bus_i(bus), .sel_i(sel),
    .pt_true_i(pt_t), .pt_comp_i(pt_c), .pt_or_i(pt_or),
    .pol_inv_i(pol), .reg_sel_i(rsel), .mc_o(mc), .fb_o(fb)
  );

  function automatic logic [15:0] model_bus();
    return loop_en ? {mq, drv[14:0]} : drv;
  endfunction

  function automatic logic model_comb(input logic [15:0] b);
    logic [3:0] loc;
    logic       sop = 1'b0;
    for (int k = 0; k < 4; k++) begin
      int line = k + 4 * int'(sel[2*k +: 2]);
      loc[k] = b[line];
    end
    for (int p = 0; p < 4; p++) begin
      logic t = 1'b1;
      for (int i = 0; i < 4; i++) begin
        if (pt_t[4*p+i] && !loc[i]) t = 1'b0;
        if (pt_c[4*p+i] &&  loc[i]) t = 1'b0;
      end
      if (pt_or[p] && t) sop = 1'b1;
    end
    return sop ^ pol;
  endfunction

  always @(posedge clk) mq <= rst ? 1'b0 : model_comb(model_bus());

  task automatic chk();
    logic e;
    e = rsel ? mq : model_comb(model_bus());
    checks += 2;
    if (mc !== e) begin
      fails++;
      $display("FAIL %s: mc_o=%0b expected %0b", cur_req, mc, e);
    end
    if (fb !== e) begin
      fails++;
      $display("FAIL %s: fb_o=%0b expected %0b", cur_req, fb, e);
    end
  endtask

  task automatic tick();
    #3 chk();
    @(negedge clk);
    #1 chk();
  endtask

  task automatic rand_cfg();
    sel   = 8'($urandom);
    pt_t  = 16'($urandom);
    pt_c  = 16'($urandom) & ~pt_t;
    if ($urandom % 3 == 0) pt_c = pt_c | (pt_t & 16'($urandom));
    pt_or = 4'($urandom);
    pol   = 1'($urandom);
    drv   = 16'($urandom);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; rsel = 1'b1; loop_en = 1'b0; drv = '0; sel = '0;
    pt_t = '0; pt_c = '0; pt_or = '0; pol = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cur_req = "R8";
    pt_or = 4'h1; pol = 1'b1;
    repeat (3) tick();
    rst = 1'b0;

    // R1: sweep each selector through its group
    cur_req = "R1";
    rsel = 1'b0; pol = 1'b0; pt_c = '0; pt_or = 4'h1;
    for (int k = 0; k < 4; k++) begin
      pt_t = 16'(1 << k);
      for (int s = 0; s < 4; s++) begin
        sel = 8'(s << (2*k));
        drv = 16'(1 << (k + 4*s));
        tick();
        drv = ~drv;
        tick();
      end
    end

    // R2: empty term and random multi-literal terms
    cur_req = "R2";
    pt_t = '0; pt_c = '0; pt_or = 4'h1; drv = 16'h5a5a;
    tick();
    for (int n = 0; n < 20; n++) begin
      rand_cfg(); pt_c = pt_c & ~pt_t; pol = 1'b0;
      tick();
    end

    // R3: contradicting literals
    cur_req = "R3";
    pol = 1'b0; sel = 8'h00; pt_or = 4'h1;
    for (int n = 0; n < 8; n++) begin
      pt_t = 16'h0001 | 16'($urandom & 16'h000e);
      pt_c = 16'h0001;
      drv  = 16'($urandom);
      tick();
    end

    // R4: no term enabled, both polarities (R5)
    cur_req = "R4";
    for (int n = 0; n < 6; n++) begin
      rand_cfg(); pt_or = '0;
      tick();
    end
    cur_req = "R5";
    for (int n = 0; n < 20; n++) begin
      rand_cfg();
      tick();
    end

    // R6: combinational mode, random
    cur_req = "R6";
    rsel = 1'b0;
    for (int n = 0; n < 30; n++) begin rand_cfg(); tick(); end

    // R7: registered mode, random
    cur_req = "R7";
    rsel = 1'b1;
    for (int n = 0; n < 40; n++) begin rand_cfg(); tick(); end

    // R8: reset in both modes
    cur_req = "R8";
    rand_cfg(); pt_t = '0; pt_c = '0; pt_or = 4'h1; pol = 1'b0;
    rst = 1'b1; rsel = 1'b1;
    tick(); tick();
    rsel = 1'b0;
    tick();
    rst = 1'b0;
    tick();

    // R9: self-feedback toggle loop
    cur_req = "R9";
    rsel = 1'b1; loop_en = 1'b1; pol = 1'b0;
    sel = 8'hc0; pt_t = '0; pt_c = 16'h0008; pt_or = 4'h1; drv = '0;
    repeat (10) tick();
    for (int n = 0; n < 20; n++) begin
      rand_cfg();
      tick();
    end
    loop_en = 1'b0;

    // R10: random mode switching
    cur_req = "R10";
    for (int n = 0; n < 40; n++) begin
      rand_cfg(); rsel = 1'($urandom);
      tick();
    end

    finish_run();
  end

endmodule